// File: doc/BRIEF.md
# Streaming Systematic Reed-Solomon Encoder (255,239)

This block takes 8-bit symbols one per clock and turns each group of 239 into a 255-symbol codeword. The 239 message symbols come out unchanged. Sixteen check symbols follow them, computed over GF(2^8) with the field polynomial x^8+x^4+x^3+x^2+1. The generator polynomial has the sixteen consecutive roots alpha^0 to alpha^15, where alpha = 2. A decoder downstream can therefore detect up to 16 damaged symbols in a codeword and repair up to 8. The check symbols are kept in a linear feedback shift register that absorbs each message symbol as it passes. Once the 239th message symbol has been taken, the register shifts its contents out, highest-degree coefficient first.

The output drives a FIFO directly, using a valid strobe and an end-of-codeword marker, so no processor touches individual symbols. While the encode request is low and no codeword is in progress, the block works as a registered bypass and copies its input to its output without coding. A codeword starts when a symbol is accepted with the request high. From then on the codeword always runs to completion, and the request is not looked at again until it has finished.

Top module: `rs_stream_encoder`

## Requirements
- R1: Each accepted message symbol appears unchanged on `out_data`, with `out_valid` high, in the cycle after it is accepted. Message symbols fill codeword positions 0 to 238 in arrival order.
- R2: Codeword positions 239 to 254 carry the check symbols. Position 0 is the coefficient of x^254, so the 255 positions read as a polynomial that vanishes at alpha^0 through alpha^15 in GF(2^8) built on 0x11D.
- R3: A message of 239 zero symbols produces 16 zero check symbols.
- R4: `in_ready` is low for exactly 16 cycles, starting in the cycle after the 239th message symbol is accepted. Input offered during those cycles is ignored and never reaches the output.
- R5: `out_valid` is high in 16 consecutive cycles for the check symbols. There is no gap after the last message symbol.
- R6: `out_last` is high together with `out_valid` on codeword position 254 only, and never in bypass.
- R7: When idle with `enc_req` low, `in_ready` is high. `out_valid` and `out_data` copy `in_valid` and `in_data` one cycle later, and `out_last` stays low.
- R8: Once a codeword has started, `enc_req` has no effect until the codeword ends. Cycles with `in_valid` low during the message phase add no output symbol and do not disturb the check symbols.
- R9: A synchronous reset clears the check register and the symbol counters. It drives `out_valid` and `out_last` low and `in_ready` high. A reset in the middle of a codeword leaves no trace in the next codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_req | input | 1 | Encode request; sampled only while idle |
| in_valid | input | 1 | Input symbol present |
| in_data | input | 8 | Input symbol |
| in_ready | output | 1 | Block can take a symbol this cycle |
| out_valid | output | 1 | Output symbol present (FIFO write strobe) |
| out_data | output | 8 | Output symbol |
| out_last | output | 1 | Final symbol of a codeword |

## Verification
The assertions take for granted that reset is held for at least two cycles before any traffic. They also take for granted that the downstream FIFO never needs to hold off the output, because the block has no way to pause its parity burst. The bypass property further assumes that `in_data` is a defined value whenever `in_valid` is high while idle. The stimulus honours all three: it holds reset for several cycles and never models a full FIFO. It drives a defined symbol on every valid cycle, including the junk symbols offered during the stall.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  // Phase of the codeword sequencer.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DATA  = 2'd1,
    PH_FLUSH = 2'd2
  } rs_phase_e;
endpackage

// File: rtl/rs_enc_sequencer.sv
module rs_enc_sequencer
  import rs_enc_pkg::*;
#(
  parameter int K_SYM = 239,
  parameter int NPAR  = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      in_valid,
  input  logic      enc_req,
  output logic      in_ready,
  output logic      absorb,
  output logic      flush,
  output logic      final_beat,
  output rs_phase_e phase
);
  localparam int CW = $clog2(K_SYM + 1);
  localparam int FW = $clog2(NPAR + 1);

  rs_phase_e     phase_q;
  logic [CW-1:0] msg_cnt_q;
  logic [FW-1:0] par_cnt_q;

  assign phase      = phase_q;
  assign in_ready   = (phase_q != PH_FLUSH);
  assign absorb     = in_valid && in_ready &&
                      ((phase_q == PH_DATA) || ((phase_q == PH_IDLE) && enc_req));
  assign flush      = (phase_q == PH_FLUSH);
  assign final_beat = flush && (par_cnt_q == FW'(NPAR - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      msg_cnt_q <= '0;
      par_cnt_q <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (absorb) begin
            if (K_SYM == 1) begin
              phase_q   <= PH_FLUSH;
              msg_cnt_q <= '0;
            end else begin
              phase_q   <= PH_DATA;
              msg_cnt_q <= CW'(1);
            end
          end
        end
        PH_DATA: begin
          if (absorb) begin
            if (msg_cnt_q == CW'(K_SYM - 1)) begin
              phase_q   <= PH_FLUSH;
              msg_cnt_q <= '0;
            end else begin
              msg_cnt_q <= msg_cnt_q + CW'(1);
            end
          end
        end
        PH_FLUSH: begin
          if (final_beat) begin
            phase_q   <= PH_IDLE;
            par_cnt_q <= '0;
          end else begin
            par_cnt_q <= par_cnt_q + FW'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr #(
  parameter int               SYM_W      = 8,
  parameter int               NPAR       = 16,
  parameter logic [SYM_W:0]   FIELD_POLY = 9'h11D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             absorb,
  input  logic             shift,
  input  logic [SYM_W-1:0] sym_in,
  output logic [SYM_W-1:0] par_top
);
  // Multiply in GF(2^SYM_W) reduced by FIELD_POLY.
  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] acc;
    logic [SYM_W-1:0] aa;
    acc = '0;
    aa  = a;
    for (int k = 0; k < SYM_W; k++) begin
      if (b[k]) acc = acc ^ aa;
      aa = {aa[SYM_W-2:0], 1'b0} ^ (aa[SYM_W-1] ? FIELD_POLY[SYM_W-1:0] : '0);
    end
    return acc;
  endfunction

  // Low-order coefficients of prod_{r<NPAR} (x + alpha^r), alpha = 2.
  function automatic logic [NPAR*SYM_W-1:0] gen_taps();
    logic [NPAR:0][SYM_W-1:0] g;
    logic [SYM_W-1:0]         root;
    logic [NPAR*SYM_W-1:0]    packed_taps;
    g    = '0;
    g[0] = SYM_W'(1);
    root = SYM_W'(1);
    for (int r = 0; r < NPAR; r++) begin
      for (int j = NPAR; j >= 1; j--) begin
        g[j] = g[j-1] ^ gf_mul(g[j], root);
      end
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, SYM_W'(2));
    end
    for (int j = 0; j < NPAR; j++) packed_taps[j*SYM_W +: SYM_W] = g[j];
    return packed_taps;
  endfunction

  localparam logic [NPAR*SYM_W-1:0] TAPS = gen_taps();

  logic [SYM_W-1:0] par_q [NPAR];
  logic [SYM_W-1:0] prod  [NPAR];
  logic [SYM_W-1:0] fb;

  assign fb      = sym_in ^ par_q[NPAR-1];
  assign par_top = par_q[NPAR-1];

  for (genvar i = 0; i < NPAR; i++) begin : g_tap
    assign prod[i] = gf_mul(TAPS[i*SYM_W +: SYM_W], fb);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPAR; i++) par_q[i] <= '0;
    end else if (absorb) begin
      par_q[0] <= prod[0];
      for (int i = 1; i < NPAR; i++) par_q[i] <= par_q[i-1] ^ prod[i];
    end else if (shift) begin
      par_q[0] <= '0;
      for (int i = 1; i < NPAR; i++) par_q[i] <= par_q[i-1];
    end
  end
endmodule

// File: rtl/rs_stream_encoder.sv
module rs_stream_encoder
  import rs_enc_pkg::*;
#(
  parameter int             SYM_W      = 8,
  parameter int             N_SYM      = 255,
  parameter int             K_SYM      = 239,
  parameter logic [SYM_W:0] FIELD_POLY = 9'h11D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_req,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             out_last
);
  localparam int NPAR = N_SYM - K_SYM;

  logic             absorb;
  logic             flush;
  logic             final_beat;
  rs_phase_e        phase;
  logic             seq_idle;
  logic [SYM_W-1:0] par_top;

  assign seq_idle = (phase == PH_IDLE);

  rs_enc_sequencer #(.K_SYM(K_SYM), .NPAR(NPAR)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .enc_req(enc_req),
    .in_ready(in_ready), .absorb(absorb), .flush(flush),
    .final_beat(final_beat), .phase(phase)
  );

  rs_parity_lfsr #(.SYM_W(SYM_W), .NPAR(NPAR), .FIELD_POLY(FIELD_POLY)) u_lfsr (
    .clk(clk), .rst(rst), .absorb(absorb), .shift(flush),
    .sym_in(in_data), .par_top(par_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_last <= final_beat;
      if (flush) begin
        out_valid <= 1'b1;
        out_data  <= par_top;
      end else if (absorb) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (seq_idle) begin
        out_valid <= in_valid;
        out_data  <= in_data;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rs_stream_encoder_chk.sv
module rs_stream_encoder_chk #(
  parameter int SYM_W = 8,
  parameter int NPAR  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enc_req,
  input logic             in_valid,
  input logic [SYM_W-1:0] in_data,
  input logic             in_ready,
  input logic             out_valid,
  input logic [SYM_W-1:0] out_data,
  input logic             out_last,
  input logic             seq_idle
);
  localparam int RW = $clog2(NPAR + 2);
  logic [RW-1:0] stall_run;

  always_ff @(posedge clk) begin
    if (rst)            stall_run <= '0;
    else if (!in_ready) stall_run <= stall_run + RW'(1);
    else                stall_run <= '0;
  end

  // R6: the end marker only rides on a valid symbol
  assert_last_valid_R6: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R6: after the final check symbol the block is ready again
  assert_ready_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    out_last |-> in_ready);

  // R5: every stalled cycle emits a check symbol next
  assert_stall_emits_R5: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> out_valid);

  // R4: a stall never exceeds the check-symbol count
  assert_stall_bound_R4: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (stall_run < RW'(NPAR)));

  // R4: a stall that ends lasted exactly the check-symbol count
  assert_stall_length_R4: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !$past(in_ready)) |-> (stall_run == RW'(NPAR)));

  // R7: bypass copies the input one cycle later
  assert_bypass_copy_R7: assert property (@(posedge clk) disable iff (rst)
    (seq_idle && in_valid && !enc_req) |=>
      (out_valid && !out_last && out_data == $past(in_data)));
endmodule

bind rs_stream_encoder rs_stream_encoder_chk #(.SYM_W(SYM_W), .NPAR(NPAR)) u_chk (
  .clk(clk), .rst(rst), .enc_req(enc_req), .in_valid(in_valid),
  .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .out_last(out_last), .seq_idle(seq_idle)
);

// File: tb/sim_rs_stream_encoder.sv
module sim_rs_stream_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int K = 239;
  localparam int N = 255;
  localparam int NP = N - K;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_req = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cyc = 0;

  logic [7:0] blk [K];
  logic [7:0] cap [512];
  bit         lst [512];
  int         stamp [512];
  int         n_cap = 0;
  int         stalls = 0;

  rs_stream_encoder u0 (
    .clk(clk), .rst(rst), .enc_req(enc_req), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && out_valid && n_cap < 512) begin
      cap[n_cap]   = out_data;
      lst[n_cap]   = out_last;
      stamp[n_cap] = cyc;
      n_cap++;
    end
  end

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; enc_req = 0; in_valid = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
  endtask

  // mode: 0 random, 1 zeros
  task automatic fill_block(input int mode);
    for (int i = 0; i < K; i++) blk[i] = (mode == 1) ? 8'h00 : 8'($urandom_range(0, 255));
  endtask

  task automatic run_block(input bit gaps, input bit drop_req);
    int i = 0;
    bit ok;
    n_cap = 0;
    stalls = 0;
    while (i < K) begin
      in_valid = !(gaps && (cyc % 3 == 0));
      in_data  = blk[i];
      enc_req  = drop_req ? (i == 0) : 1'b1;
      @(negedge clk);
      ok = in_ready && in_valid;
      @(posedge clk); #1;
      if (ok) i++;
    end
    in_valid = 1'b1; in_data = 8'hA5; enc_req = 1'b0;
    for (int j = 0; j < NP; j++) begin
      @(negedge clk);
      if (!in_ready) stalls++;
      tick();
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R4 ready back after stall", in_ready, 1);
    repeat (3) tick();
  endtask

  task automatic check_block(input bit expect_zero);
    bit ok;
    chk(n_cap == N, "R1 codeword length", n_cap, N);
    chk(stalls == NP, "R4 stall cycles", stalls, NP);
    ok = 1;
    for (int p = 0; p < K; p++) if (cap[p] !== blk[p]) ok = 0;
    chk(ok, "R1 message symbols unchanged", ok, 1);
    for (int r = 0; r < NP; r++) begin
      logic [7:0] s = 8'h00;
      logic [7:0] ar = 8'h01;
      for (int q = 0; q < r; q++) ar = bmul(ar, 8'h02);
      for (int p = 0; p < N; p++) s = bmul(s, ar) ^ cap[p];
      if (s !== 8'h00) begin
        chk(0, "R2 syndrome", s, 0);
        break;
      end
    end
    chk(1, "R2 syndromes checked", 1, 1);
    ok = 1;
    for (int p = 0; p < N; p++) if (lst[p] != (p == N - 1)) ok = 0;
    chk(ok, "R6 end marker only on position 254", ok, 1);
    ok = 1;
    for (int p = K; p < N; p++) if (stamp[p] != stamp[K-1] + (p - K + 1)) ok = 0;
    chk(ok, "R5 check symbols contiguous", ok, 1);
    if (expect_zero) begin
      ok = 1;
      for (int p = K; p < N; p++) if (cap[p] !== 8'h00) ok = 0;
      chk(ok, "R3 zero message gives zero parity", ok, 1);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(out_valid == 0, "R9 out_valid after reset", out_valid, 0);
    chk(out_last == 0, "R9 out_last after reset", out_last, 0);
    chk(in_ready == 1, "R9 in_ready after reset", in_ready, 1);
    tick();
  endtask

  task automatic t_bypass();
    enc_req = 1'b0;
    for (int j = 0; j < 6; j++) begin
      bit v = (j != 2);
      logic [7:0] d = 8'h30 + 8'(j);
      in_valid = v; in_data = d;
      chk(in_ready == 1, "R7 ready in bypass", in_ready, 1);
      tick();
      chk(out_valid == v, "R7 bypass valid", out_valid, v);
      if (v) chk(out_data == d, "R7 bypass data", out_data, d);
      chk(out_last == 0, "R7 no marker in bypass", out_last, 0);
    end
    in_valid = 1'b0;
    tick();
  endtask

  task automatic t_zero();
    fill_block(1); run_block(0, 0); check_block(1);
  endtask

  task automatic t_random();
    fill_block(0); run_block(0, 0); check_block(0);
  endtask

  task automatic t_gaps_drop();
    // R8: gaps in input and enc_req dropped after the first symbol
    fill_block(0); run_block(1, 1); check_block(0);
  endtask

  task automatic t_reset_mid();
    enc_req = 1'b1;
    for (int i = 0; i < 50; i++) begin
      in_valid = 1'b1; in_data = 8'(i * 7 + 3);
      tick();
    end
    in_valid = 1'b0;
    do_reset();
    @(negedge clk);
    chk(out_valid == 0, "R9 idle after mid-block reset", out_valid, 0);
    chk(in_ready == 1, "R9 ready after mid-block reset", in_ready, 1);
    tick();
    fill_block(0); run_block(0, 0); check_block(0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset_state();
    t_bypass();
    t_zero();
    t_random();
    t_random();
    t_gaps_drop();
    t_bypass();
    t_reset_mid();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule